// File: doc/BRIEF.md
# Polarity-Aware Column Charge-Share Timer

This block decides, once per display line, whether the column outputs of a panel driver should be briefly tied together so that stored column charge is redistributed before the new line is driven. It watches a line-load strobe and a line polarity input. Both arrive from outside the data-clock domain and are synchronized first. Polarity is captured when the strobe rises. When the strobe falls, the captured polarity is compared with the one captured for the line before. A share window of a selectable length, counted in data clocks, is opened only if the polarity differs.

The comparison matters under multi-line inversion schemes. In those schemes polarity holds for several lines in a row, so sharing on every line would only waste the window. A configuration input can override the comparison and share on every line. A two-bit selector chooses the window length. When the selector is left at zero, the window is the shortest one.

Top module: `csh_share_ctrl`

## Requirements
- R1: The window length is 16 << time_sel data clocks: 00 gives 16, 01 gives 32, 10 gives 64 and 11 gives 128. share_en stays high for exactly that many consecutive clock cycles and then returns low.
- R2: share_en rises on the third rising clock edge after a falling edge of line_load is presented at the input. Two edges are spent in the synchronizer and one in the window register.
- R3: line_pol is captured at each rising edge of line_load. When share_all is 0, a window opens on the following line_load falling edge only if the captured value differs from the one captured on the line before.
- R4: Under n-line inversion (polarity held for 2 or 3 lines in a row), no window opens on any line transition where polarity does not change.
- R5: With share_all = 1, every falling edge of line_load opens a window, whatever the polarity.
- R6: A falling edge that qualifies for sharing and arrives while a window is open restarts the count from zero. share_en stays high without a gap until the full new window has elapsed.
- R7: A falling edge that does not qualify for sharing and arrives while a window is open leaves that window's end time unchanged.
- R8: time_sel is captured when a window opens. A change during an open window does not alter that window's length.
- R9: A synchronous reset (rst = 1) drives share_en low on the next clock edge. It clears the polarity history to 0, so that after reset a first line with polarity 0 opens no window and a first line with polarity 1 opens one.
- R10: share_en never rises except in the cycle after a qualifying falling edge of the synchronized strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock; all state and the window count run on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| line_load | input | 1 | Line-load strobe, asynchronous; rise captures polarity, fall marks the line boundary |
| line_pol | input | 1 | Polarity of the line being loaded, asynchronous |
| time_sel | input | SEL_W | Window length select, 16 << time_sel clocks |
| share_all | input | 1 | 1 = share on every line, 0 = share only on polarity change |
| share_en | output | 1 | Registered charge-share enable |

## Verification
The bench sweeps every window length, with the comparison both on and off, against one-, two- and three-line inversion patterns. A design that counts one clock too many or too few, or that decodes the selector wrongly, shows up as a wrong high-time. A design that skips the polarity history shows up as windows on lines where the polarity did not change. The overlap cases go after errors in restart handling. A design that ignores a qualifying restart ends 8 cycles early. One that restarts on a non-qualifying edge runs long. One that reads the selector live stretches the window to 128 clocks. The reset cases catch a history cleared to the wrong value, which inverts the decision for the first line after reset.

// File: rtl/csh_pkg.sv
package csh_pkg;

  // Polarity captured for the line being loaded and for the line before.
  typedef struct packed {
    logic cur;
    logic prev;
  } pol_hist_t;

  // Window length in clocks for a given selector value.
  function automatic int unsigned win_cycles(input int unsigned base_log2,
                                             input int unsigned sel);
    return 32'd1 << (base_log2 + sel);
  endfunction

  // Share decision for one line boundary.
  function automatic logic share_wanted(input logic force_all,
                                        input pol_hist_t h);
    return force_all | (h.cur ^ h.prev);
  endfunction

endpackage

// File: rtl/csh_sync.sv
module csh_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/csh_edge.sv
module csh_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise,
  output logic fall
);

  logic sig_d;

  always_ff @(posedge clk) begin
    if (rst) sig_d <= 1'b0;
    else     sig_d <= sig;
  end

  assign rise = sig & ~sig_d;
  assign fall = ~sig & sig_d;

endmodule

// File: rtl/csh_polhist.sv
module csh_polhist
  import csh_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      capture,
  input  logic      pol_in,
  output pol_hist_t hist
);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
    end else if (capture) begin
      hist.prev <= hist.cur;
      hist.cur  <= pol_in;
    end
  end

endmodule

// File: rtl/csh_window.sv
module csh_window
  import csh_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 4,
  parameter int LEN_W     = BASE_LOG2 + (1 << SEL_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  output logic             active,
  output logic [LEN_W-1:0] cnt,
  output logic [LEN_W-1:0] len
);

  localparam logic [LEN_W-1:0] LEN_RST = LEN_W'(win_cycles(BASE_LOG2, 0));

  logic last;
  assign last = (cnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      len    <= LEN_RST;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
      len    <= LEN_W'(win_cycles(BASE_LOG2, int'(sel)));
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/csh_share_ctrl.sv
module csh_share_ctrl
  import csh_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2,
  parameter int BASE_LOG2   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_load,
  input  logic             line_pol,
  input  logic [SEL_W-1:0] time_sel,
  input  logic             share_all,
  output logic             share_en
);

  localparam int LEN_W = BASE_LOG2 + (1 << SEL_W);

  // Named internal events, visible to the bound checker.
  logic [1:0]       sync_q;
  logic             load_s;
  logic             pol_s;
  logic             rise_evt;
  logic             fall_evt;
  pol_hist_t        hist;
  logic             want_share;
  logic             win_start;
  logic [LEN_W-1:0] win_cnt;
  logic [LEN_W-1:0] win_len;

  csh_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({line_pol, line_load}),
    .q   (sync_q)
  );

  assign load_s = sync_q[0];
  assign pol_s  = sync_q[1];

  csh_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .sig  (load_s),
    .rise (rise_evt),
    .fall (fall_evt)
  );

  csh_polhist u_hist (
    .clk     (clk),
    .rst     (rst),
    .capture (rise_evt),
    .pol_in  (pol_s),
    .hist    (hist)
  );

  assign want_share = share_wanted(share_all, hist);
  assign win_start  = fall_evt & want_share;

  csh_window #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .LEN_W(LEN_W)) u_win (
    .clk    (clk),
    .rst    (rst),
    .start  (win_start),
    .sel    (time_sel),
    .active (share_en),
    .cnt    (win_cnt),
    .len    (win_len)
  );

endmodule

// File: rtl/csh_share_chk.sv
module csh_share_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             fall_evt,
  input logic             want_share,
  input logic             share_all,
  input logic             share_en,
  input logic [LEN_W-1:0] win_cnt,
  input logic [LEN_W-1:0] win_len
);

  logic restart;
  assign restart = fall_evt & want_share;

  // R1
  window_hold_chk: assert property (@(posedge clk) disable iff (rst)
    share_en && !restart && (win_cnt != win_len - 1'b1) |=> share_en && (win_cnt == $past(win_cnt) + 1'b1));

  // R1
  window_end_chk: assert property (@(posedge clk) disable iff (rst)
    share_en && !restart && (win_cnt == win_len - 1'b1) |=> !share_en);

  // R10
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(share_en) |-> $past(restart));

  // R3
  no_flip_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fall_evt && !want_share && !share_en |=> !share_en);

  // R5
  force_share_chk: assert property (@(posedge clk) disable iff (rst)
    share_all && fall_evt |=> share_en && (win_cnt == '0));

  // R6
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> share_en && (win_cnt == '0));

  // R8
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    share_en && !restart |=> $stable(win_len));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !share_en);

endmodule

bind csh_share_ctrl csh_share_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fall_evt   (fall_evt),
  .want_share (want_share),
  .share_all  (share_all),
  .share_en   (share_en),
  .win_cnt    (win_cnt),
  .win_len    (win_len)
);

// File: tb/sim_csh_share_ctrl.sv
module sim_csh_share_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_load = 1'b0;
  logic       line_pol = 1'b0;
  logic [1:0] time_sel = 2'd0;
  logic       share_all = 1'b0;
  logic       share_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic model_prev = 1'b0;

  always #4 clk = ~clk;

  csh_share_ctrl u0 (
    .clk       (clk),
    .rst       (rst),
    .line_load (line_load),
    .line_pol  (line_pol),
    .time_sel  (time_sel),
    .share_all (share_all),
    .share_en  (share_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int sel);
    int n = 16;
    for (int k = 0; k < sel; k++) n = n * 2;
    return n;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    model_prev = 1'b0;
  endtask

  // One line: set polarity, pulse the strobe, observe the window.
  task automatic run_line(input logic p, input string tag);
    int n;
    int first;
    int hi;
    bit expect_share;
    n = exp_len(int'(time_sel));
    expect_share = share_all || (p != model_prev);
    model_prev = p;
    @(negedge clk); line_pol = p;
    @(negedge clk); line_load = 1'b1;
    repeat (3) @(negedge clk);
    line_load = 1'b0;
    first = -1;
    hi = 0;
    for (int i = 1; i <= n + 8; i++) begin
      @(negedge clk);
      if (share_en) begin
        hi++;
        if (first < 0) first = i;
      end
    end
    if (expect_share) begin
      check(first == 3, "R2", first, 3);
      check(hi == n, tag, hi, n);
    end else begin
      check(hi == 0, tag, hi, 0);
    end
  endtask

  // Overlap cases: a second line boundary or a selector change during a 16-clock window.
  task automatic run_overlap(input bit second_line, input bit second_flip,
                             input bit change_sel, input int exp_hi,
                             input int exp_last, input string tag);
    logic p1;
    int hi;
    int last;
    p1 = ~model_prev;
    model_prev = p1;
    @(negedge clk); line_pol = p1;
    @(negedge clk); line_load = 1'b1;
    repeat (3) @(negedge clk);
    line_load = 1'b0;
    hi = 0;
    last = -1;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (share_en) begin
        hi++;
        last = i;
      end
      if (second_line && i == 4) begin
        line_pol = second_flip ? ~p1 : p1;
        model_prev = second_flip ? ~p1 : p1;
      end
      if (second_line && i == 5) line_load = 1'b1;
      if (second_line && i == 8) line_load = 1'b0;
      if (change_sel && i == 5) time_sel = 2'd3;
    end
    check(hi == exp_hi, tag, hi, exp_hi);
    check(last == exp_last, tag, last, exp_last);
    time_sel = 2'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    model_prev = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(share_en == 1'b0, "R9", int'(share_en), 0);

    // R9 history cleared to 0: first line at polarity 0 gives no window
    run_line(1'b0, "R9");
    run_line(1'b1, "R9");

    // Sweep: every selector, compare on/off, inversion periods 1..3 (R1 R3 R4 R5)
    for (int s = 0; s < 4; s++) begin
      for (int f = 0; f < 2; f++) begin
        for (int k = 1; k <= 3; k++) begin
          @(negedge clk);
          time_sel = 2'(s);
          share_all = f[0];
          for (int ln = 0; ln < 6; ln++) begin
            logic p;
            p = 1'(((ln / k) % 2)) ^ 1'b1;
            if (f == 1)      run_line(p, "R5");
            else if (k > 1)  run_line(p, "R4");
            else if (s == 0) run_line(p, "R1");
            else             run_line(p, "R3");
          end
        end
      end
    end

    @(negedge clk);
    share_all = 1'b0;
    time_sel = 2'd0;

    // R6 qualifying restart: old window i=3..18, new one i=11..26
    run_overlap(1'b1, 1'b1, 1'b0, 24, 26, "R6");
    // R7 non-qualifying boundary during a window: end stays at i=18
    run_overlap(1'b1, 1'b0, 1'b0, 16, 18, "R7");
    // R8 selector change mid-window: length stays 16
    run_overlap(1'b0, 1'b0, 1'b1, 16, 18, "R8");

    // R9 reset during an open window
    @(negedge clk); line_pol = ~model_prev;
    @(negedge clk); line_load = 1'b1;
    repeat (3) @(negedge clk);
    line_load = 1'b0;
    repeat (5) @(negedge clk);
    check(share_en == 1'b1, "R9", int'(share_en), 1);
    rst = 1'b1;
    @(negedge clk);
    check(share_en == 1'b0, "R9", int'(share_en), 0);
    rst = 1'b0;
    model_prev = 1'b0;
    run_line(1'b0, "R9");
    run_line(1'b1, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule